// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA engine for a parallel disk interface. Software points it at a table of physical region descriptors in memory, picks a direction and sets the start bit. The engine then walks the table entry by entry. For each entry it moves 16-bit words between the buffer that entry describes and the disk device, using the device's request/acknowledge handshake. It stops on the entry marked as the last one.

Each descriptor is two dwords at the table pointer, which advances by 8 per entry. The first dword is the buffer byte address; its bit 0 is ignored. The second dword carries the byte count in bits 15:0, where 0 means 65536 and bit 0 is ignored, and the end-of-table flag in bit 31. Every access on the memory port waits for a response. A response may signal an error.

The host sees an 8-byte window as two dwords, chosen by `hst_dsel`, with one byte enable per byte lane. Dword 0 holds, from lane 0 upward: command, a vendor byte, status, and a second vendor byte. Dword 1 is the table pointer. Command bit 0 is start. Command bit 3 is direction: 1 writes memory and 0 reads memory. Status bit 0 is active, bit 1 is error, bit 2 is interrupt, and bits 5 and 6 are drive-capable flags. A good completion reads status[2:0] = 3'b100.

Top module: `bmdma_channel`

## Requirements
- R1: After reset every register reads 0. The vendor bytes (dword 0, lanes 1 and 3) read 0 and ignore writes. The table pointer is writable per byte lane and its bits 1:0 read 0. A read returns data on `hst_rdata` in the cycle after the read strobe.
- R2: Writing command bit 0 = 1 while it is 0 sets status bit 0 (active) and starts fetching descriptors: the address dword at the pointer, then the count dword at pointer+4.
- R3: With command bit 3 = 0, the engine reads one halfword per device request from consecutive buffer addresses (step 2). It presents each halfword on `dev_rdata` together with a one-cycle `dev_ack`.
- R4: With command bit 3 = 1, each word taken from `dev_wdata` at a one-cycle `dev_ack` is written to memory as a halfword at consecutive buffer addresses.
- R5: Descriptors are consumed in table order. Active clears once the entry with bit 31 set has been fully moved.
- R6: Writing command bit 0 = 0 clears active within two cycles and withdraws any memory request.
- R7: A memory error response sets status bit 1, clears active and ends all memory requests.
- R8: If the device still requests data after the last entry is exhausted while start is 1, status bit 1 is set.
- R9: Status bit 2 is set by a rising edge of `dev_irq` only while start is 1. An edge while start is 0 leaves it at 0.
- R10: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: Status bits 5 and 6 are read/write and have no effect on a transfer.
- R12: A write to command bit 3 while start is 1 is ignored.
- R13: A memory request holds `mem_addr` and `mem_we` stable until its response arrives. Every memory address is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe, one cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_dsel | input | 1 | 0 = dword at offset 0, 1 = pointer dword at offset 4 |
| hst_be | input | 4 | Byte-lane enables for writes |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | 1 = write request |
| mem_half | output | 1 | 1 = halfword data access, 0 = descriptor dword read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, halfword in bits 15:0 |
| mem_rsp | input | 1 | Response pulse, one per request |
| mem_err | input | 1 | Error flag qualifying `mem_rsp` |
| mem_rdata | input | 32 | Read data; a halfword read returns in bits 15:0 |
| dev_req | input | 1 | Device wants a word moved |
| dev_ack | output | 1 | One-cycle word handshake |
| dev_wdata | input | 16 | Word from the device |
| dev_rdata | output | 16 | Word to the device |
| dev_irq | input | 1 | Device interrupt level |

## Verification
A wrong descriptor pointer or remaining-count shows up as wrong buffer addresses on the memory port within one descriptor. It also shows up as an early or late drop of the active bit, or as a false error when the device keeps requesting after the table ends. A broken handshake sequence shows as duplicated or missing words in the device's captured stream, or in memory, by the next word. Status faults (a lost set-over-clear, a direction change mid-transfer, an interrupt latched while unarmed) are visible on the next register read.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // command register bits
  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  // status register bits
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;
  // byte lane of the status register inside dword 0
  localparam int ST_LANE = 2;
  // bytes per descriptor and offset of its count dword
  localparam int DESC_BYTES = 8;
  localparam int DESC_CNT_OFS = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH_A, S_FETCH_C, S_WAIT, S_MRD, S_DACK, S_MWR, S_DRAIN, S_HALT
  } eng_state_t;
endpackage

// File: rtl/bmdma_edge.sv
module bmdma_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0;
      rise  <= 1'b0;
    end else begin
      din_q <= din;
      rise  <= din & ~din_q;
    end
  end

  // R9
  rise_pulse_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hst_sel,
  input  logic          hst_wr,
  input  logic          hst_dsel,
  input  logic [HW/8-1:0] hst_be,
  input  logic [HW-1:0] hst_wdata,
  output logic [HW-1:0] hst_rdata,
  input  logic          eng_active,
  input  logic          eng_err,
  input  logic          irq_rise,
  output logic          go,
  output logic          go_pulse,
  output logic          dir_to_mem,
  output logic [HW-1:2] tbl_base
);
  localparam int LANES = HW / 8;
  localparam int ST_OFS = ST_LANE * 8;

  logic [HW-1:0] ptr_q;
  logic st_err, st_irq, cap0, cap1;
  logic wr_cmd, wr_st, rd_any;
  logic [7:0] cmd_byte, st_byte;

  assign wr_cmd = hst_sel & hst_wr & ~hst_dsel & hst_be[0];
  assign wr_st  = hst_sel & hst_wr & ~hst_dsel & hst_be[ST_LANE];
  assign rd_any = hst_sel & ~hst_wr;

  assign cmd_byte = {4'b0, dir_to_mem, 2'b0, go};
  assign st_byte  = {1'b0, cap1, cap0, 2'b0, st_irq, st_err, eng_active};
  assign tbl_base = ptr_q[HW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      go         <= 1'b0;
      go_pulse   <= 1'b0;
      dir_to_mem <= 1'b0;
      st_err     <= 1'b0;
      st_irq     <= 1'b0;
      cap0       <= 1'b0;
      cap1       <= 1'b0;
      ptr_q      <= '0;
      hst_rdata  <= '0;
    end else begin
      go_pulse <= 1'b0;
      if (wr_cmd) begin
        go       <= hst_wdata[CMD_GO];
        go_pulse <= hst_wdata[CMD_GO] & ~go;
        if (!go) dir_to_mem <= hst_wdata[CMD_DIR];
      end
      // set wins over write-one-to-clear
      if (eng_err) st_err <= 1'b1;
      else if (wr_st && hst_wdata[ST_OFS+ST_ERR]) st_err <= 1'b0;
      if (irq_rise && go) st_irq <= 1'b1;
      else if (wr_st && hst_wdata[ST_OFS+ST_IRQ]) st_irq <= 1'b0;
      if (wr_st) begin
        cap0 <= hst_wdata[ST_OFS+ST_CAP0];
        cap1 <= hst_wdata[ST_OFS+ST_CAP1];
      end
      if (hst_sel && hst_wr && hst_dsel) begin
        for (int k = 0; k < LANES; k++) begin
          if (hst_be[k]) ptr_q[8*k +: 8] <= hst_wdata[8*k +: 8];
        end
        ptr_q[1:0] <= 2'b00;
      end
      if (rd_any) begin
        if (hst_dsel) hst_rdata <= {ptr_q[HW-1:2], 2'b00};
        else          hst_rdata <= {{(HW-32){1'b0}}, 8'h00, st_byte, 8'h00, cmd_byte};
      end
    end
  end

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (rst) eng_err |=> st_err);
  // R10
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_st && hst_wdata[ST_OFS+ST_ERR] && !eng_err) |=> !st_err);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst) (irq_rise && go) |=> st_irq);
  // R12
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst) go |=> $stable(dir_to_mem));
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
  import bmdma_pkg::*;
#(
  parameter int MEM_W = 32,
  parameter int DEV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             go_pulse,
  input  logic             dir_to_mem,
  input  logic [MEM_W-1:2] tbl_base,
  output logic             active,
  output logic             err_pulse,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_half,
  output logic [MEM_W-1:0] mem_addr,
  output logic [MEM_W-1:0] mem_wdata,
  input  logic             mem_rsp,
  input  logic             mem_err,
  input  logic [MEM_W-1:0] mem_rdata,
  input  logic             dev_req,
  output logic             dev_ack,
  input  logic [DEV_W-1:0] dev_wdata,
  output logic [DEV_W-1:0] dev_rdata
);
  localparam int REM_W = CNT_W + 1;
  localparam int EOT_BIT = MEM_W - 1;
  localparam logic [MEM_W-1:0] STEP = MEM_W'(DEV_W / 8);
  localparam logic [REM_W-1:0] STEP_R = REM_W'(DEV_W / 8);
  localparam logic [REM_W-1:0] FULL_LEN = REM_W'(1) << CNT_W;
  localparam logic [MEM_W-1:0] D_BYTES = MEM_W'(DESC_BYTES);
  localparam logic [MEM_W-1:0] D_CNT = MEM_W'(DESC_CNT_OFS);

  eng_state_t state;
  logic [MEM_W-1:0] tbl_ptr, cur_addr;
  logic [REM_W-1:0] remain;
  logic             last_ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      active    <= 1'b0;
      err_pulse <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_half  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dev_ack   <= 1'b0;
      dev_rdata <= '0;
      tbl_ptr   <= '0;
      cur_addr  <= '0;
      remain    <= '0;
      last_ent  <= 1'b0;
    end else begin
      dev_ack   <= 1'b0;
      err_pulse <= 1'b0;
      if (!go) begin
        state   <= S_IDLE;
        active  <= 1'b0;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (go_pulse) begin
              active   <= 1'b1;
              tbl_ptr  <= {tbl_base, 2'b00};
              mem_addr <= {tbl_base, 2'b00};
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_half <= 1'b0;
              state    <= S_FETCH_A;
            end
          end
          S_FETCH_A: begin
            if (mem_rsp) begin
              if (mem_err) begin
                mem_req <= 1'b0; active <= 1'b0; err_pulse <= 1'b1; state <= S_HALT;
              end else begin
                cur_addr <= {mem_rdata[MEM_W-1:1], 1'b0};
                mem_addr <= tbl_ptr + D_CNT;
                state    <= S_FETCH_C;
              end
            end
          end
          S_FETCH_C: begin
            if (mem_rsp) begin
              mem_req <= 1'b0;
              if (mem_err) begin
                active <= 1'b0; err_pulse <= 1'b1; state <= S_HALT;
              end else begin
                remain   <= (mem_rdata[CNT_W-1:0] == '0) ? FULL_LEN
                            : {1'b0, mem_rdata[CNT_W-1:1], 1'b0};
                last_ent <= mem_rdata[EOT_BIT];
                tbl_ptr  <= tbl_ptr + D_BYTES;
                state    <= S_WAIT;
              end
            end
          end
          S_WAIT: begin
            if (remain == '0) begin
              if (last_ent) begin
                active <= 1'b0;
                state  <= S_DRAIN;
              end else begin
                mem_addr <= tbl_ptr;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_half <= 1'b0;
                state    <= S_FETCH_A;
              end
            end else if (dev_req && !dev_ack) begin
              if (dir_to_mem) begin
                dev_ack <= 1'b1;
                state   <= S_DACK;
              end else begin
                mem_addr <= cur_addr;
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_half <= 1'b1;
                state    <= S_MRD;
              end
            end
          end
          S_DACK: begin
            mem_wdata <= {{(MEM_W-DEV_W){1'b0}}, dev_wdata};
            mem_addr  <= cur_addr;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_half  <= 1'b1;
            state     <= S_MWR;
          end
          S_MWR: begin
            if (mem_rsp) begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              if (mem_err) begin
                active <= 1'b0; err_pulse <= 1'b1; state <= S_HALT;
              end else begin
                cur_addr <= cur_addr + STEP;
                remain   <= remain - STEP_R;
                state    <= S_WAIT;
              end
            end
          end
          S_MRD: begin
            if (mem_rsp) begin
              mem_req <= 1'b0;
              if (mem_err) begin
                active <= 1'b0; err_pulse <= 1'b1; state <= S_HALT;
              end else begin
                dev_rdata <= mem_rdata[DEV_W-1:0];
                dev_ack   <= 1'b1;
                cur_addr  <= cur_addr + STEP;
                remain    <= remain - STEP_R;
                state     <= S_WAIT;
              end
            end
          end
          S_DRAIN: begin
            if (dev_req) begin
              err_pulse <= 1'b1;
              state     <= S_HALT;
            end
          end
          default: state <= S_HALT;
        endcase
      end
    end
  end

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) dev_ack |=> !dev_ack);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp && go) |=> (!go || (mem_req && $stable(mem_addr) && $stable(mem_we))));
  // R13
  addr_even_chk: assert property (@(posedge clk) disable iff (rst) mem_req |-> !mem_addr[0]);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst) err_pulse |-> (!active && !mem_req));
  // R6
  stop_chk: assert property (@(posedge clk) disable iff (rst) !go |=> (!active && !mem_req));
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel #(
  parameter int MEM_W = 32,
  parameter int DEV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_sel,
  input  logic             hst_wr,
  input  logic             hst_dsel,
  input  logic [3:0]       hst_be,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_half,
  output logic [MEM_W-1:0] mem_addr,
  output logic [MEM_W-1:0] mem_wdata,
  input  logic             mem_rsp,
  input  logic             mem_err,
  input  logic [MEM_W-1:0] mem_rdata,
  input  logic             dev_req,
  output logic             dev_ack,
  input  logic [DEV_W-1:0] dev_wdata,
  output logic [DEV_W-1:0] dev_rdata,
  input  logic             dev_irq
);
  logic go, go_pulse, dir_to_mem, active, err_pulse, irq_rise;
  logic [MEM_W-1:2] tbl_base;

  bmdma_edge u_edge (
    .clk(clk), .rst(rst), .din(dev_irq), .rise(irq_rise)
  );

  bmdma_regs #(.HW(MEM_W)) u_regs (
    .clk(clk), .rst(rst),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_dsel(hst_dsel),
    .hst_be(hst_be), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .eng_active(active), .eng_err(err_pulse), .irq_rise(irq_rise),
    .go(go), .go_pulse(go_pulse), .dir_to_mem(dir_to_mem), .tbl_base(tbl_base)
  );

  bmdma_engine #(.MEM_W(MEM_W), .DEV_W(DEV_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst),
    .go(go), .go_pulse(go_pulse), .dir_to_mem(dir_to_mem), .tbl_base(tbl_base),
    .active(active), .err_pulse(err_pulse),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );
endmodule

// File: tb/bmdma_channel_bench.sv
module bmdma_channel_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_sel = 1'b0, hst_wr = 1'b0, hst_dsel = 1'b0;
  logic [3:0] hst_be = 4'h0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic mem_req, mem_we, mem_half, mem_rsp, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic dev_req, dev_ack, dev_irq;
  logic [15:0] dev_wdata, dev_rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bmdma_channel u_bmdma_channel (
    .clk(clk), .rst(rst),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_dsel(hst_dsel), .hst_be(hst_be),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_irq(dev_irq)
  );

  // memory model: 4 KB, error for addresses 0xF00-0xFFF
  logic [31:0] mem_arr [0:1023];
  logic busy = 1'b0;
  int lat = 0;
  logic [31:0] l_addr = '0, l_wdata = '0;
  logic l_we = 1'b0, l_half = 1'b0;
  initial begin mem_rsp = 1'b0; mem_err = 1'b0; mem_rdata = '0; end

  always @(posedge clk) begin
    mem_rsp <= 1'b0;
    mem_err <= 1'b0;
    if (rst) busy <= 1'b0;
    else if (busy) begin
      if (lat == 0) begin
        busy <= 1'b0;
        mem_rsp <= 1'b1;
        if (l_addr[11:8] == 4'hF) mem_err <= 1'b1;
        else if (l_we) begin
          if (l_addr[1]) mem_arr[l_addr[11:2]][31:16] <= l_wdata[15:0];
          else           mem_arr[l_addr[11:2]][15:0]  <= l_wdata[15:0];
        end else if (l_half)
          mem_rdata <= {16'h0, l_addr[1] ? mem_arr[l_addr[11:2]][31:16] : mem_arr[l_addr[11:2]][15:0]};
        else
          mem_rdata <= mem_arr[l_addr[11:2]];
      end else lat <= lat - 1;
    end else if (mem_req && !mem_rsp) begin
      busy <= 1'b1; lat <= 1;
      l_addr <= mem_addr; l_we <= mem_we; l_half <= mem_half; l_wdata <= mem_wdata;
    end
  end

  // device model
  int dev_total = 0, dev_done = 0;
  logic [15:0] dev_src [0:15];
  logic [15:0] dev_cap [0:15];
  assign dev_req = (dev_done < dev_total);
  assign dev_wdata = dev_src[dev_done[3:0]];
  always @(posedge clk) begin
    if (rst) dev_done <= 0;
    else if (dev_ack) begin
      dev_cap[dev_done[3:0]] <= dev_rdata;
      dev_done <= dev_done + 1;
    end
  end

  // request-hold monitor, sampled at the falling edge
  int hold_viol = 0;
  logic p_req = 1'b0, p_rsp = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (!rst && p_req && !p_rsp && mem_req && mem_addr != p_addr) hold_viol++;
    p_req = mem_req; p_rsp = mem_rsp; p_addr = mem_addr;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic dsel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_dsel = dsel; hst_be = be; hst_wdata = d;
    @(negedge clk);
    hst_sel = 1'b0; hst_wr = 1'b0; hst_be = 4'h0;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_rd(input logic dsel, output logic [31:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_dsel = dsel;
    @(negedge clk);
    hst_sel = 1'b0;
    d = hst_rdata;
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [31:0] d;
    host_rd(1'b0, d);
    s = d[23:16];
  endtask

  task automatic dev_load(input int n, input logic [15:0] base_val);
    for (int i = 0; i < n; i++) dev_src[(dev_done + i) % 16] = base_val + 16'(i) * 16'h1111;
    dev_total = dev_done + n;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    host_rd(1'b0, d); check("R1 reset dword0", d, 32'h0);
    host_rd(1'b1, d); check("R1 reset pointer", d, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    host_wr(1'b1, 4'hF, 32'h1234_5677);
    host_rd(1'b1, d); check("R1 pointer low bits", d, 32'h1234_5674);
    host_wr(1'b1, 4'b0010, 32'h0000_AB00);
    host_rd(1'b1, d); check("R1 pointer byte lane", d, 32'h1234_AB74);
    host_wr(1'b0, 4'b1010, 32'hFFFF_FFFF);
    host_rd(1'b0, d); check("R1 vendor bytes", d, 32'h0);
    host_wr(1'b0, 4'b0100, 32'h0060_0000);
    host_rd(1'b0, d); check("R11 capable bits", d, 32'h0060_0000);
    host_wr(1'b0, 4'b0100, 32'h0);
  endtask

  task automatic t_to_dev();
    logic [7:0] s;
    mem_arr[10'h040] = 32'h0000_0400; mem_arr[10'h041] = 32'h0000_0004;
    mem_arr[10'h042] = 32'h0000_0800; mem_arr[10'h043] = 32'h8000_0004;
    mem_arr[10'h100] = 32'hB002_A001; mem_arr[10'h200] = 32'hD004_C003;
    host_wr(1'b1, 4'hF, 32'h0000_0100);
    host_wr(1'b0, 4'b0001, 32'h01);
    rd_status(s); check("R2 active after start", {24'h0, s}, 32'h01);
    dev_load(4, 16'h0);
    repeat (120) @(negedge clk);
    check("R3 word0", {16'h0, dev_cap[0]}, 32'hA001);
    check("R3 word1", {16'h0, dev_cap[1]}, 32'hB002);
    check("R5 word2 second entry", {16'h0, dev_cap[2]}, 32'hC003);
    check("R5 word3", {16'h0, dev_cap[3]}, 32'hD004);
    rd_status(s); check("R5 active clear at end", {24'h0, s}, 32'h00);
    @(negedge clk); dev_irq = 1'b1; repeat (3) @(negedge clk); dev_irq = 1'b0;
    rd_status(s); check("R9 good completion 100b", {29'h0, s[2:0]}, 32'h4);
    host_wr(1'b0, 4'b0100, 32'h0);
    rd_status(s); check("R10 write 0 keeps irq", {24'h0, s}, 32'h04);
    host_wr(1'b0, 4'b0100, 32'h0004_0000);
    rd_status(s); check("R10 w1c irq", {24'h0, s}, 32'h00);
    host_wr(1'b0, 4'b0001, 32'h0);
  endtask

  task automatic t_to_mem();
    logic [7:0] s;
    logic [31:0] d;
    host_wr(1'b0, 4'b0100, 32'h0060_0000);
    mem_arr[10'h080] = 32'h0000_0600; mem_arr[10'h081] = 32'h8000_0006;
    mem_arr[10'h180] = 32'h0; mem_arr[10'h181] = 32'h0;
    host_wr(1'b1, 4'hF, 32'h0000_0200);
    dev_load(3, 16'h1111);
    host_wr(1'b0, 4'b0001, 32'h09);
    repeat (120) @(negedge clk);
    check("R4 memory dword0", mem_arr[10'h180], 32'h2222_1111);
    check("R4 memory dword1", mem_arr[10'h181], 32'h0000_3333);
    rd_status(s); check("R11 flags kept, clean end", {24'h0, s}, 32'h60);
    host_wr(1'b0, 4'b0001, 32'h0);
    host_wr(1'b0, 4'b0001, 32'h0);
    host_rd(1'b0, d); check("R11 stop keeps flags", d, 32'h0060_0000);
    host_wr(1'b0, 4'b0100, 32'h0);
  endtask

  task automatic t_lock_stop();
    logic [31:0] d;
    logic [7:0] s;
    host_wr(1'b1, 4'hF, 32'h0000_0100);
    host_wr(1'b0, 4'b0001, 32'h01);
    host_wr(1'b0, 4'b0001, 32'h09);
    host_rd(1'b0, d); check("R12 dir ignored while running", {24'h0, d[7:0]}, 32'h01);
    host_wr(1'b0, 4'b0001, 32'h00);
    rd_status(s); check("R6 stop clears active", {24'h0, s}, 32'h00);
    check("R6 no memory request", {31'h0, mem_req}, 32'h0);
  endtask

  task automatic t_mem_err();
    logic [7:0] s;
    host_wr(1'b1, 4'hF, 32'h0000_0F00);
    host_wr(1'b0, 4'b0001, 32'h01);
    repeat (20) @(negedge clk);
    rd_status(s); check("R7 error, not active", {24'h0, s}, 32'h02);
    check("R7 requests ended", {31'h0, mem_req}, 32'h0);
    host_wr(1'b0, 4'b0100, 32'h0);
    rd_status(s); check("R10 write 0 keeps err", {24'h0, s}, 32'h02);
    host_wr(1'b0, 4'b0100, 32'h0002_0000);
    rd_status(s); check("R10 w1c err", {24'h0, s}, 32'h00);
    host_wr(1'b0, 4'b0001, 32'h0);
  endtask

  task automatic t_overrun();
    logic [7:0] s;
    mem_arr[10'h0C0] = 32'h0000_0400; mem_arr[10'h0C1] = 32'h8000_0002;
    host_wr(1'b1, 4'hF, 32'h0000_0300);
    dev_load(2, 16'h0);
    host_wr(1'b0, 4'b0001, 32'h01);
    repeat (80) @(negedge clk);
    rd_status(s); check("R8 overrun error", {24'h0, s}, 32'h02);
    host_wr(1'b0, 4'b0001, 32'h0);
    dev_total = dev_done;
    host_wr(1'b0, 4'b0100, 32'h0002_0000);
  endtask

  task automatic t_irq_unarmed();
    logic [7:0] s;
    @(negedge clk); dev_irq = 1'b1; repeat (3) @(negedge clk); dev_irq = 1'b0;
    repeat (2) @(negedge clk);
    rd_status(s); check("R9 irq ignored when unarmed", {24'h0, s}, 32'h00);
    check("R13 request held until response", hold_viol, 32'h0);
  endtask

  initial begin
    dev_irq = 1'b0;
    for (int i = 0; i < 1024; i++) mem_arr[i] = '0;
    for (int i = 0; i < 16; i++) begin dev_src[i] = '0; dev_cap[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_to_dev();
    t_to_mem();
    t_lock_stop();
    t_mem_err();
    t_overrun();
    t_irq_unarmed();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule